// File: doc/BRIEF.md
# Parallel Extrinsic Memory Router

This block sits between a group of parallel soft-output decoder engines and the extrinsic-information storage they share. The storage is cut into as many equal banks as there are engines, and each bank has its own single port, so every engine can read or write one word in the same clock cycle. A full crossbar carries each engine's request to the bank it names and carries the read word back to the engine that asked for it.

Two addressing modes are offered. In direct mode engine j is bound to bank j and its address is used as a row inside that bank; this serves natural-order half-iterations of one codeword, where all engines walk the same offset of their own sub-block, and also the case where each engine decodes a separate short codeword held in its own bank. In permuted mode each engine presents a global interleaved address. The block length is split into sub-blocks of a runtime length M, and the router finds the bank as the address divided by M and the row as the remainder, using comparisons against multiples of M instead of a divider. A contention-free interleaver guarantees distinct banks; if that promise is broken, or an address falls outside the block, the router raises a fault and suppresses every write and every read response of that cycle.

Top module: `llr_bank_router`

## Requirements
- R1: While reset is held and in the cycle after it is released, `rvalid_o` is all zero.
- R2: In direct mode (`mode_i` = 0) a read by port j returns the word stored in bank j at the row given by the low ROW_W bits of its address.
- R3: In direct mode all ports may access their own banks at different rows in the same cycle, and `fault_o` never rises.
- R4: In permuted mode (`mode_i` = 1) an address A is placed in bank floor(A / M) at row A mod M, with M taken from `sub_len_i` in that cycle; a word written there is visible through direct-mode port floor(A / M) at row A mod M.
- R5: Read data and its valid flag appear in the cycle after the request is presented.
- R6: In permuted mode each read word is returned on the port that requested it, whatever bank it came from, and reads and writes from different ports mix freely in one cycle.
- R7: In permuted mode, when two requesting ports resolve to the same bank, `fault_o` is high in that cycle, no write of that cycle takes effect and no read of that cycle returns a valid flag.
- R8: In permuted mode, a requesting port whose address is at least NPORT·M, or any request while M is zero or larger than the bank depth, raises `fault_o` with the same suppression as R7.
- R9: A write request never produces a read valid flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = direct, 1 = permuted addressing |
| sub_len_i | input | ROW_W+1 | Sub-block length M for permuted mode |
| req_i | input | NPORT | Per-port access request |
| wr_i | input | NPORT | Per-port write (1) or read (0) |
| addr_i | input | NPORT·ADDR_W | Per-port address, port j in slice j |
| wdata_i | input | NPORT·DATA_W | Per-port write data |
| rdata_o | output | NPORT·DATA_W | Per-port read data, one cycle after request |
| rvalid_o | output | NPORT | Per-port read data valid |
| fault_o | output | 1 | Bank collision or address range error this cycle |

## Verification
The bench builds the router with four ports, eight-bit words and sixteen-row banks, which is the largest parallelism the block targets and gives a six-bit global address space. Running M at both sixteen (a power of two, where the split is a plain bit slice) and ten (where every bank boundary falls mid-way and the remainder needs a real subtraction) exercises the comparator chain on both aligned and unaligned sub-blocks. The small depth lets a full direct-mode fill seed every bank so that suppressed writes, range errors and crossbar returns can all be checked against a bench-side copy of the memory.

// File: rtl/llr_rt_pkg.sv
package llr_rt_pkg;

   typedef enum logic {
      RT_DIRECT = 1'b0,
      RT_PERM   = 1'b1
   } rt_mode_e;

   // Width of a bank index for a given port count.
   function automatic int bank_bits(input int nport);
      return (nport > 1) ? $clog2(nport) : 1;
   endfunction

endpackage

// File: rtl/llr_rt_split.sv
// Per-port address splitter: bank index and row from a direct or permuted address.
module llr_rt_split
   import llr_rt_pkg::*;
#(
   parameter int NPORT   = 4,
   parameter int ROW_W   = 4,
   parameter int PORT_ID = 0,
   localparam int BANK_W = bank_bits(NPORT),
   localparam int ADDR_W = ROW_W + BANK_W
) (
   input  logic              mode_i,
   input  logic [ROW_W:0]    sub_len_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [BANK_W-1:0] bank_o,
   output logic [ROW_W-1:0]  row_o,
   output logic              range_err_o
);

   localparam logic [ROW_W:0] DEPTH_V = (ROW_W+1)'(1 << ROW_W);

   logic [ADDR_W:0]   mult [NPORT+1];
   logic [ADDR_W:0]   a_ext;
   logic [BANK_W-1:0] perm_bank;

   assign a_ext = {1'b0, addr_i};

   for (genvar k = 0; k <= NPORT; k++) begin : g_mult
      assign mult[k] = (ADDR_W+1)'(k) * {{BANK_W{1'b0}}, sub_len_i};
   end

   always_comb begin
      perm_bank = '0;
      for (int k = 1; k < NPORT; k++) begin
         if (a_ext >= mult[k]) perm_bank = BANK_W'(k);
      end
   end

   always_comb begin
      if (rt_mode_e'(mode_i) == RT_PERM) begin
         bank_o      = perm_bank;
         row_o       = ROW_W'(a_ext - mult[perm_bank]);
         range_err_o = (a_ext >= mult[NPORT]) || (sub_len_i > DEPTH_V);
      end else begin
         bank_o      = BANK_W'(PORT_ID);
         row_o       = addr_i[ROW_W-1:0];
         range_err_o = 1'b0;
      end
   end

endmodule

// File: rtl/llr_rt_bank.sv
// One independent single-port bank with registered read.
module llr_rt_bank #(
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   localparam int DEPTH = 1 << ROW_W
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem[row_i] <= wdata_i;
      if (re_i) rdata_o <= mem[row_i];
   end

endmodule

// File: rtl/llr_bank_router.sv
module llr_bank_router
   import llr_rt_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   localparam int BANK_W = bank_bits(NPORT),
   localparam int ADDR_W = ROW_W + BANK_W
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    mode_i,
   input  logic [ROW_W:0]          sub_len_i,
   input  logic [NPORT-1:0]        req_i,
   input  logic [NPORT-1:0]        wr_i,
   input  logic [NPORT*ADDR_W-1:0] addr_i,
   input  logic [NPORT*DATA_W-1:0] wdata_i,
   output logic [NPORT*DATA_W-1:0] rdata_o,
   output logic [NPORT-1:0]        rvalid_o,
   output logic                    fault_o
);

   if (NPORT < 2 || NPORT > 4) begin : g_bad_nport
      $error("llr_bank_router: NPORT must lie in 2..4");
   end
   if (ROW_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("llr_bank_router: ROW_W and DATA_W must be positive");
   end

   logic [BANK_W-1:0] bsel  [NPORT];
   logic [ROW_W-1:0]  rsel  [NPORT];
   logic [NPORT-1:0]  rerr;
   logic [NPORT-1:0]  hit   [NPORT];
   logic [NPORT-1:0]  multi;
   logic              fault;

   logic [ROW_W-1:0]  b_row [NPORT];
   logic [DATA_W-1:0] b_wd  [NPORT];
   logic [NPORT-1:0]  b_wr, b_any, b_we, b_re;
   logic [DATA_W-1:0] b_q   [NPORT];

   logic [BANK_W-1:0] sel_q [NPORT];
   logic [NPORT-1:0]  rvalid_q;

   // Address split, one per port.
   for (genvar j = 0; j < NPORT; j++) begin : g_port
      llr_rt_split #(
         .NPORT   (NPORT),
         .ROW_W   (ROW_W),
         .PORT_ID (j)
      ) i_split (
         .mode_i      (mode_i),
         .sub_len_i   (sub_len_i),
         .addr_i      (addr_i[j*ADDR_W +: ADDR_W]),
         .bank_o      (bsel[j]),
         .row_o       (rsel[j]),
         .range_err_o (rerr[j])
      );
   end

   // Forward crossbar: which port drives which bank, and collision detection.
   always_comb begin
      for (int b = 0; b < NPORT; b++) begin
         for (int j = 0; j < NPORT; j++) begin
            hit[b][j] = req_i[j] && (bsel[j] == BANK_W'(b));
         end
         multi[b] = |(hit[b] & (hit[b] - NPORT'(1)));
      end
   end

   assign fault = (|(rerr & req_i)) || (|multi);

   always_comb begin
      for (int b = 0; b < NPORT; b++) begin
         b_row[b] = '0;
         b_wd[b]  = '0;
         b_wr[b]  = 1'b0;
         b_any[b] = 1'b0;
         for (int j = NPORT - 1; j >= 0; j--) begin
            if (hit[b][j]) begin
               b_row[b] = rsel[j];
               b_wd[b]  = wdata_i[j*DATA_W +: DATA_W];
               b_wr[b]  = wr_i[j];
               b_any[b] = 1'b1;
            end
         end
         b_we[b] = b_any[b] &&  b_wr[b] && !fault;
         b_re[b] = b_any[b] && !b_wr[b] && !fault;
      end
   end

   for (genvar b = 0; b < NPORT; b++) begin : g_bank
      llr_rt_bank #(
         .DATA_W (DATA_W),
         .ROW_W  (ROW_W)
      ) i_bank (
         .clk_i   (clk_i),
         .we_i    (b_we[b]),
         .re_i    (b_re[b]),
         .row_i   (b_row[b]),
         .wdata_i (b_wd[b]),
         .rdata_o (b_q[b])
      );
   end

   // Return crossbar: bank choice registered alongside the request.
   always_ff @(posedge clk_i) begin
      for (int j = 0; j < NPORT; j++) sel_q[j] <= bsel[j];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) rvalid_q <= '0;
      else       rvalid_q <= req_i & ~wr_i & {NPORT{!fault}};
   end

   for (genvar j = 0; j < NPORT; j++) begin : g_ret
      assign rdata_o[j*DATA_W +: DATA_W] = b_q[sel_q[j]];
   end

   assign rvalid_o = rvalid_q;
   assign fault_o  = fault;

endmodule

// File: rtl/llr_bank_router_chk.sv
module llr_bank_router_chk
   import llr_rt_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int ROW_W  = 4,
   localparam int BANK_W = bank_bits(NPORT),
   localparam int ADDR_W = ROW_W + BANK_W
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              mode_i,
   input logic [ROW_W:0]    sub_len_i,
   input logic [NPORT-1:0]  req_i,
   input logic [NPORT-1:0]  wr_i,
   input logic [ADDR_W-1:0] a0_i,
   input logic [ADDR_W-1:0] a1_i,
   input logic [NPORT-1:0]  rvalid_i,
   input logic              fault_i
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      rst_i |=> (rvalid_i == '0));

   // R7
   fault_kills_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      fault_i |=> (rvalid_i == '0));

   // R9
   valid_needs_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rvalid_i & ~$past(req_i & ~wr_i)) == '0);

   // R3
   direct_no_fault_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == 1'b0) |-> !fault_i);

   // R7
   same_addr_fault_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i && req_i[0] && req_i[1] && (a0_i == a1_i)) |-> fault_i);

   // R8
   zero_len_fault_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i && req_i[0] && (sub_len_i == '0)) |-> fault_i);

endmodule

bind llr_bank_router llr_bank_router_chk #(
   .NPORT (NPORT),
   .ROW_W (ROW_W)
) i_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .mode_i    (mode_i),
   .sub_len_i (sub_len_i),
   .req_i     (req_i),
   .wr_i      (wr_i),
   .a0_i      (addr_i[0 +: ADDR_W]),
   .a1_i      (addr_i[ADDR_W +: ADDR_W]),
   .rvalid_i  (rvalid_o),
   .fault_i   (fault_o)
);

// File: tb/test_llr_bank_router.sv
`timescale 1ns/1ps
module test_llr_bank_router;

   localparam int NP = 4;
   localparam int DW = 8;
   localparam int RW = 4;
   localparam int AW = 6;
   localparam int DEP = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst;
   logic          mode;
   logic [RW:0]   sub_len;
   logic [NP-1:0] req, wr;
   logic [AW-1:0] addr [NP];
   logic [DW-1:0] wd   [NP];
   logic [NP*AW-1:0] addr_v;
   logic [NP*DW-1:0] wd_v, rd_v;
   logic [NP-1:0] rvalid;
   logic          fault;

   always_comb begin
      for (int j = 0; j < NP; j++) begin
         addr_v[j*AW +: AW] = addr[j];
         wd_v[j*DW +: DW]   = wd[j];
      end
   end

   llr_bank_router #(.NPORT(NP), .DATA_W(DW), .ROW_W(RW)) i_llr_bank_router (
      .clk_i(clk), .rst_i(rst), .mode_i(mode), .sub_len_i(sub_len),
      .req_i(req), .wr_i(wr), .addr_i(addr_v), .wdata_i(wd_v),
      .rdata_o(rd_v), .rvalid_o(rvalid), .fault_o(fault));

   int errs = 0;
   int checks = 0;
   logic [DW-1:0] mdl [NP][DEP];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      req = '0; wr = '0;
      for (int j = 0; j < NP; j++) begin addr[j] = '0; wd[j] = '0; end
   endtask

   // One access cycle with checks of fault, read return and model update.
   task automatic go(input string tag);
      int eb [NP];
      int er [NP];
      int cnt [NP];
      bit bad;
      bit ev;
      bad = 1'b0;
      for (int b = 0; b < NP; b++) cnt[b] = 0;
      for (int j = 0; j < NP; j++) begin
         eb[j] = 0; er[j] = 0;
         if (req[j]) begin
            if (!mode) begin
               eb[j] = j; er[j] = int'(addr[j][RW-1:0]);
            end else if (sub_len == 0 || sub_len > DEP || int'(addr[j]) >= NP * int'(sub_len)) begin
               bad = 1'b1;
            end else begin
               eb[j] = int'(addr[j]) / int'(sub_len);
               er[j] = int'(addr[j]) % int'(sub_len);
            end
            if (!bad) cnt[eb[j]]++;
         end
      end
      for (int b = 0; b < NP; b++) if (cnt[b] > 1) bad = 1'b1;
      #1;
      chk(fault == bad, {tag, " fault"}, int'(fault), int'(bad));
      @(posedge clk); @(negedge clk);
      for (int j = 0; j < NP; j++) begin
         ev = req[j] && !wr[j] && !bad;
         chk(rvalid[j] == ev, {tag, " R5 R9 rvalid"}, int'(rvalid[j]), int'(ev));
         if (ev) chk(rd_v[j*DW +: DW] == mdl[eb[j]][er[j]], {tag, " rdata"},
                     int'(rd_v[j*DW +: DW]), int'(mdl[eb[j]][er[j]]));
      end
      if (!bad)
         for (int j = 0; j < NP; j++)
            if (req[j] && wr[j]) mdl[eb[j]][er[j]] = wd[j];
      idle();
   endtask

   task automatic t_reset();
      rst = 1'b1; mode = 1'b0; sub_len = 5'd16; idle();
      repeat (3) @(negedge clk);
      chk(rvalid == '0, "R1 rvalid in reset", int'(rvalid), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(rvalid == '0, "R1 rvalid after reset", int'(rvalid), 0);
   endtask

   task automatic t_direct();
      mode = 1'b0;
      for (int r = 0; r < DEP; r++) begin
         req = '1; wr = '1;
         for (int j = 0; j < NP; j++) begin
            addr[j] = AW'(r); wd[j] = DW'(j * 16 + r + 1);
         end
         go("R3 fill");
      end
      req = '1;
      for (int j = 0; j < NP; j++) addr[j] = AW'(15 - 3 * j);
      go("R2 read rows");
      req = '1;
      for (int j = 0; j < NP; j++) addr[j] = AW'(32 + 7);
      go("R2 upper bits ignored");
   endtask

   task automatic t_perm16();
      mode = 1'b1; sub_len = 5'd16;
      req = '1; wr = '1;
      addr[0] = 37; addr[1] = 5; addr[2] = 60; addr[3] = 20;
      wd[0] = 8'hA1; wd[1] = 8'hB2; wd[2] = 8'hC3; wd[3] = 8'hD4;
      go("R4 write M16");
      req = '1;
      addr[0] = 60; addr[1] = 20; addr[2] = 37; addr[3] = 5;
      go("R6 read rotated");
      mode = 1'b0; req = 4'b0100; addr[2] = 5;
      go("R4 direct view of bank2 row5");
   endtask

   task automatic t_perm10();
      mode = 1'b1; sub_len = 5'd10;
      req = '1; wr = '1;
      addr[0] = 25; addr[1] = 9; addr[2] = 39; addr[3] = 10;
      wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
      go("R4 write M10");
      req = '1; wr = 4'b0100;
      addr[0] = 39; addr[1] = 10; addr[2] = 9; addr[3] = 25; wd[2] = 8'h77;
      go("R6 mixed read write");
      mode = 1'b0; req = 4'b1111;
      addr[0] = 9; addr[1] = 0; addr[2] = 5; addr[3] = 9;
      go("R4 direct view M10");
   endtask

   task automatic t_conflict();
      mode = 1'b1; sub_len = 5'd16;
      req = 4'b0111; wr = 4'b0011;
      addr[0] = 3; addr[1] = 7; addr[2] = 40;
      wd[0] = 8'h99; wd[1] = 8'h98;
      go("R7 bank collision");
      req = 4'b0011; addr[0] = 12; addr[1] = 12;
      go("R7 same address read");
      mode = 1'b0; req = 4'b0001; addr[0] = 3;
      go("R7 write blocked row3");
      req = 4'b0001; addr[0] = 7;
      go("R7 write blocked row7");
   endtask

   task automatic t_range();
      mode = 1'b1; sub_len = 5'd10;
      req = 4'b0011; wr = 4'b0010; addr[0] = 5; addr[1] = 45; wd[1] = 8'h55;
      go("R8 address past block");
      sub_len = 5'd0; req = 4'b0001; addr[0] = 0;
      go("R8 zero length");
      sub_len = 5'd20; req = 4'b0001; addr[0] = 1;
      go("R8 length over depth");
      sub_len = 5'd10; req = 4'b0001; addr[0] = 5;
      go("R8 write at 45 left bank0 row5 alone");
   endtask

   initial begin
      t_reset();
      t_direct();
      t_perm16();
      t_perm10();
      t_conflict();
      t_range();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule